// File: doc/BRIEF.md
# Mode-Switchable Receive Buffer

This block buffers the words a UART receiver produces until software reads them. It runs in one of two modes, selected at run time by a single control input. In queue mode it is a 16-entry circular buffer. In single mode it holds exactly one word and behaves as a queue one entry deep. Pointer wrap, the full condition and the receiver's accept condition always follow the depth of the current mode. That depth is a power of two, so every index is reduced by masking with the depth minus one.

The receiver offers a word on the push side and may only push while `can_accept_o` is high. The register-read path sees the oldest word on `pop_data_o` in the same cycle that it asserts `pop_i`. The read position then advances at the clock edge. The `empty_o` and `full_o` status flags are registered.

When the mode input changes from queue mode to single mode, the buffer is flushed. The read position, the occupancy and the flags return to their reset values.

Top module: `rx_fifo_buf`

## Requirements
- R1: After reset the block is in single mode, with `empty_o`=1, `full_o`=0 and `can_accept_o`=1.
- R2: In queue mode (`fifo_en_i`=1), words leave in the order they arrived. While the buffer is not empty, `pop_data_o` shows the oldest word during the cycle in which `pop_i` is applied.
- R3: `can_accept_o` is high exactly when the occupancy is below the effective depth: 16 in queue mode, 1 in single mode. A push while it is low is dropped and leaves the stored words unchanged.
- R4: `full_o` is 1 in the cycle after the occupancy reaches the effective depth of the mode just sampled. It returns to 0 after any pop that leaves the occupancy below that depth.
- R5: `empty_o` goes to 0 after an accepted push. It goes to 1 after a pop that removes the last word.
- R6: A pop while the buffer is empty changes no flag, no pointer and no stored word. The word on `pop_data_o` in that case is stale and carries no meaning.
- R7: A clock edge at which the registered mode is queue mode and `fifo_en_i` is 0 flushes the buffer. Afterwards `empty_o`=1, `full_o`=0 and the read position is 0. A push or pop in that same cycle is lost.
- R8: In single mode one push fills the buffer and sets `full_o`. A further push is dropped. A pop returns the held word.
- R9: In queue mode the read and write positions wrap from 15 to 0 without any loss or reordering over long streams.
- R10: A push and a pop in the same cycle both take effect when the buffer is neither empty nor full. When it is empty, only the push takes effect. When it is full, only the pop takes effect, because `can_accept_o` is low.
- R11: Switching from single mode to queue mode keeps a held word. `full_o` clears, and the buffer then accepts up to 16 words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 selects queue mode (depth 16), 0 selects single mode (depth 1) |
| push_i | input | 1 | Receiver offers a word this cycle |
| push_data_i | input | DATA_W | Received word |
| can_accept_o | output | 1 | Occupancy is below the effective depth |
| pop_i | input | 1 | Data register read this cycle |
| pop_data_o | output | DATA_W | Word at the read position |
| empty_o | output | 1 | Buffer holds no word |
| full_o | output | 1 | Occupancy equals the effective depth |

## Verification
A wrong occupancy count shows up at the ports within one cycle. It appears as a flag that disagrees with the number of words pushed and popped, or as `can_accept_o` refusing or admitting a word wrongly. A wrong read or write position is only visible when the affected word reaches the head of the queue, so that error can surface up to 16 pops later as a reordered or duplicated `pop_data_o`. For that reason the bench compares every flag and the head word on every cycle against a queue model, across many wraps and across mode changes in both directions.

// File: rtl/rx_fifo_buf_pkg.sv
package rx_fifo_buf_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_QUEUE  = 1'b1
  } rxb_mode_e;
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DEPTH-1:0][DATA_W-1:0] mem;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (wr_en_i && (wr_idx_i == PTR_W'(g))) begin
        q <= wr_data_i;
      end
    end
    assign mem[g] = q;
  end

  assign rd_data_o = mem[rd_idx_i];
endmodule

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
  import rx_fifo_buf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic [PTR_W-1:0] rd_idx_o,
  output logic             can_accept_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] DEPTH_Q = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_S = CNT_W'(1);
  localparam logic [PTR_W-1:0] MASK_Q  = PTR_W'(DEPTH - 1);

  rxb_mode_e        mode_q, mode_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             empty_q, full_q;

  logic [CNT_W-1:0] depth_cur, depth_nxt;
  logic [PTR_W-1:0] mask_cur;
  logic             push_ok, pop_ok, flush;

  assign mode_d    = fifo_en_i ? MODE_QUEUE : MODE_SINGLE;
  assign depth_cur = (mode_q == MODE_QUEUE) ? DEPTH_Q : DEPTH_S;
  assign depth_nxt = (mode_d == MODE_QUEUE) ? DEPTH_Q : DEPTH_S;
  assign mask_cur  = (mode_q == MODE_QUEUE) ? MASK_Q : '0;
  assign flush     = (mode_q == MODE_QUEUE) && (mode_d == MODE_SINGLE);

  assign can_accept_o = cnt_q < depth_cur;
  assign push_ok      = push_i && can_accept_o;
  assign pop_ok       = pop_i && (cnt_q != '0);

  // write slot: head plus occupancy, reduced by current depth
  assign wr_idx_o = (rd_ptr_q + cnt_q[PTR_W-1:0]) & mask_cur;
  assign wr_en_o  = push_ok;
  assign rd_idx_o = rd_ptr_q;

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (pop_ok) begin
      rd_ptr_d = (rd_ptr_q + PTR_W'(1)) & mask_cur;
    end
    cnt_d = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    if (flush) begin
      rd_ptr_d = '0;
      cnt_d    = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_SINGLE;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      empty_q  <= 1'b1;
      full_q   <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      empty_q  <= (cnt_d == '0);
      full_q   <= (cnt_d == depth_nxt);
    end
  end

  assign empty_o = empty_q;
  assign full_o  = full_q;

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= depth_cur);

  p_push_clears_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && can_accept_o && !flush |=> !empty_o);

  p_full_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && (mode_d == mode_q) |=> full_o);

  p_empty_pop_inert_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && empty_o && !push_i && !flush |=> empty_o && $stable(rd_ptr_q));

  p_flush_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> empty_o && !full_o && (rd_ptr_q == '0) && can_accept_o);

  p_single_idx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SINGLE) |-> (rd_ptr_q == '0) && (wr_idx_o == '0));
endmodule

// File: rtl/rx_fifo_buf.sv
module rx_fifo_buf #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic              can_accept_o,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              empty_o,
  output logic              full_o
);
  logic             wr_en;
  logic [PTR_W-1:0] wr_idx, rd_idx;

  rxb_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fifo_en_i   (fifo_en_i),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .rd_idx_o    (rd_idx),
    .can_accept_o(can_accept_o),
    .empty_o     (empty_o),
    .full_o      (full_o)
  );

  rxb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_data_i(push_data_i),
    .rd_idx_i (rd_idx),
    .rd_data_o(pop_data_o)
  );

  p_flags_exclusive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));

  p_full_refuses_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !can_accept_o);
endmodule

// File: tb/test_rx_fifo_buf.sv
module test_rx_fifo_buf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0;
  logic       push = 1'b0;
  logic [7:0] push_data = '0;
  logic       pop = 1'b0;
  logic       can_accept, empty, full;
  logic [7:0] pop_data;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [7:0] q[$];
  bit         mode_m = 1'b0;

  always #2.5 clk = ~clk;

  rx_fifo_buf i_rx_fifo_buf (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .fifo_en_i   (fifo_en),
    .push_i      (push),
    .push_data_i (push_data),
    .can_accept_o(can_accept),
    .pop_i       (pop),
    .pop_data_o  (pop_data),
    .empty_o     (empty),
    .full_o      (full)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int depth_of(input bit m);
    return m ? 16 : 1;
  endfunction

  task automatic compare(input string tag);
    chk(tag, "empty_o (R5)", int'(empty), int'(q.size() == 0));
    chk(tag, "full_o (R4)", int'(full), int'(q.size() == depth_of(mode_m)));
    chk(tag, "can_accept_o (R3)", int'(can_accept), int'(q.size() < depth_of(mode_m)));
    if (q.size() != 0) chk(tag, "pop_data_o (R2)", int'(pop_data), int'(q[0]));
  endtask

  // compare state, drive one cycle, update the model at the edge
  task automatic step(input string tag, input bit en, input bit psh,
                      input logic [7:0] d, input bit pp);
    int  dep;
    bit  acc, tk;
    @(negedge clk);
    compare(tag);
    fifo_en = en; push = psh; push_data = d; pop = pp;
    @(posedge clk);
    dep = depth_of(mode_m);
    acc = psh && (q.size() < dep);
    tk  = pp && (q.size() > 0);
    if (tk)  void'(q.pop_front());
    if (acc) q.push_back(d);
    if (mode_m && !en) q.delete();
    mode_m = en;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    bit         en_r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    step("R1", 1, 0, 8'h00, 0);            // reset state, then enter queue mode
    for (int i = 0; i < 16; i++) step("R2", 1, 1, 8'(8'h10 + i), 0);
    step("R3", 1, 1, 8'hEE, 0);            // dropped when full
    step("R4", 1, 1, 8'hEF, 0);
    for (int i = 0; i < 16; i++) step("R2", 1, 0, 8'h00, 1);
    step("R6", 1, 0, 8'h00, 1);            // pops while empty
    step("R6", 1, 0, 8'h00, 1);
    step("R6", 1, 1, 8'h31, 0);
    for (int i = 0; i < 3; i++) step("R9", 1, 1, 8'(8'h40 + i), 0);
    for (int i = 0; i < 40; i++) step("R10", 1, 1, 8'(i * 7), 1);
    for (int i = 0; i < 5; i++) step("R9", 1, 0, 8'h00, 1);
    step("R10", 1, 1, 8'h99, 1);           // push+pop while empty
    for (int i = 0; i < 16; i++) step("R10", 1, 1, 8'(8'hA0 + i), 0);
    step("R10", 1, 1, 8'hFE, 1);           // push+pop while full
    step("R4", 1, 0, 8'h00, 0);
    step("R7", 0, 1, 8'hAA, 1);            // flush on leaving queue mode
    step("R7", 0, 0, 8'h00, 0);
    step("R8", 0, 1, 8'h5A, 0);
    step("R8", 0, 1, 8'h6B, 0);            // dropped, depth 1
    step("R8", 0, 0, 8'h00, 1);
    step("R8", 0, 1, 8'h77, 0);
    step("R11", 1, 0, 8'h00, 0);           // enter queue mode holding one
    for (int i = 0; i < 15; i++) step("R11", 1, 1, 8'(8'hC0 + i), 0);
    step("R11", 1, 1, 8'hDD, 0);
    for (int i = 0; i < 17; i++) step("R11", 1, 0, 8'h00, 1);

    lfsr = 8'h5B;
    en_r = 1'b1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if ((i % 97) == 96) en_r = ~en_r;
      step("R9", en_r, lfsr[0] | lfsr[3], lfsr, lfsr[1] & lfsr[6]);
    end
    step("R2", en_r, 0, 8'h00, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule